// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Selectable Read Mode

This block moves 36-bit words from one clock domain to another. A producer on the write clock pushes words with a write enable; a consumer on the read clock takes them out through a registered output. The two clocks need no fixed relation. Each side has its own active-low asynchronous reset, and the bench drives both resets together.

A static mode input selects how the read side behaves. In standard mode the read flag means "a word is waiting in memory". A read request issued while the flag is HIGH loads that word into the output register on the same edge. In fall-through mode the read flag means "the output register holds a fresh, unconsumed word". Words move into the output register without any request, and a read request consumes the word that is shown. The write flag is HIGH whenever a storage location is free. Pointers cross between the domains as Gray codes through two-flop synchronizers, and full is detected with one extra wrap bit.

The read side is a two-state machine. In RD_VOID the output register holds no unconsumed word; standard mode always stays in this state. In RD_HELD the output register holds a fresh word (fall-through mode only). Its transitions are:
- RD_VOID to RD_HELD: fall-through mode, and a word is available.
- RD_HELD to RD_HELD: a request arrives and a further word is available (it is reloaded).
- RD_HELD to RD_VOID: a request arrives and memory is empty.

The write side is also a two-state machine. It sits in WR_HOLD while in reset and moves from WR_HOLD to WR_OPEN on the first write-clock edge after reset is released. It stays in WR_OPEN after that.

Top module: `xclk_fifo`

## Requirements
- R1: While reset is asserted, wr_ready and rd_valid are LOW. wr_ready goes HIGH on the first write-clock edge after reset is released. rd_valid stays LOW until a word arrives.
- R2: Words leave in the order they were accepted, with none lost and none duplicated, for any pattern of enables on the two clocks.
- R3: In standard mode (fwft_mode=0), rd_valid rises on the second rising read-clock edge after a write into an empty FIFO.
- R4: In standard mode, rd_en with rd_valid HIGH loads the next word into rd_data on that edge. rd_en with rd_valid LOW is ignored, and rd_data keeps its value.
- R5: In fall-through mode (fwft_mode=1), a word written into an empty FIFO appears on rd_data, and rd_valid rises, on the third rising read-clock edge after the write, with rd_en held LOW.
- R6: In fall-through mode, while rd_valid is HIGH and rd_en is LOW, rd_data and rd_valid hold. rd_en with rd_valid HIGH consumes the shown word.
- R7: wr_ready is LOW when 2^ADDR_W words are stored in memory. A write while wr_ready is LOW is ignored and never appears at the output.
- R8: After a read frees the next location to be written in a full FIFO, wr_ready returns HIGH on the second rising write-clock edge after that read.
- R9: A word held in the output register counts as read from memory. In fall-through mode the FIFO therefore accepts 2^ADDR_W+1 words before wr_ready falls, and in standard mode it accepts 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active LOW |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | HIGH when a location is free (Input Ready / not Full) |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active LOW |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| rd_valid | output | 1 | Output Ready (fall-through mode) or not Empty (standard mode) |
| fwft_mode | input | 1 | 1 selects fall-through mode, 0 selects standard mode; static between resets |

## Verification
The bench builds the block with DATA_W=36 and ADDR_W=3, so the FIFO holds eight words. With that depth, full and the ignored write after full take only a handful of cycles, and the bench fills the FIFO completely in both modes. It also checks that fall-through mode takes one extra word. The write clock (8 ns) and read clock (13 ns) are offset by half a nanosecond, so their edges never coincide. This makes the two- and three-edge flag latencies exact counts. Enable patterns at full rate, random rate and sparse rate are crossed between the two sides in both modes.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    typedef enum logic { RD_VOID = 1'b0, RD_HELD = 1'b1 } rd_state_e;
    typedef enum logic { WR_HOLD = 1'b0, WR_OPEN = 1'b1 } wr_state_e;
endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 11
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/push_side.sv
module push_side
    import fifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              we,
    output logic              wr_ready
);
    localparam int P     = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    wr_state_e    st_q, st_d;
    logic [P-1:0] wbin, wbin_nx, rbin_s, fill_w;
    logic         full;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WR_HOLD: st_d = WR_OPEN;
            WR_OPEN: st_d = WR_OPEN;
        endcase
    end

    // full: write pointer one lap ahead of the synchronized read pointer
    assign full    = (wgray == {~rgray_sync[P-1 -: 2], rgray_sync[P-3:0]});
    assign wbin_nx = wbin + P'(1);

    // outputs
    always_comb begin
        wr_ready = (st_q == WR_OPEN) && !full;
        we       = wr_en && wr_ready;
        waddr    = wbin[ADDR_W-1:0];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WR_HOLD;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            st_q <= st_d;
            if (we) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < P; i++) rbin_s[i] = ^(rgray_sync >> i);
    end
    assign fill_w = wbin - rbin_s;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_w <= P'(DEPTH));

    // R7
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> $stable(wgray));
endmodule

// File: rtl/pop_side.sv
module pop_side
    import fifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwft_mode,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int P     = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    rd_state_e    st_q, st_d;
    logic [P-1:0] rbin, rbin_nx, wbin_s, fill_r;
    logic         avail, load;

    assign avail   = (rgray != wgray_sync);
    assign rbin_nx = rbin + P'(1);

    // next-state logic
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            RD_VOID: begin
                if (fwft_mode) begin
                    if (avail) begin
                        load = 1'b1;
                        st_d = RD_HELD;
                    end
                end else if (rd_en && avail) begin
                    load = 1'b1;
                end
            end
            RD_HELD: begin
                if (!fwft_mode) begin
                    st_d = RD_VOID;
                end else if (rd_en) begin
                    if (avail) load = 1'b1;
                    else       st_d = RD_VOID;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        rd_valid = fwft_mode ? (st_q == RD_HELD) : avail;
        raddr    = rbin[ADDR_W-1:0];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= RD_VOID;
            rbin    <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else begin
            st_q <= st_d;
            if (load) begin
                rbin    <= rbin_nx;
                rgray   <= rbin_nx ^ (rbin_nx >> 1);
                rd_data <= mem_q;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < P; i++) wbin_s[i] = ^(wgray_sync >> i);
    end
    assign fill_r = wbin_s - rbin;

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_r <= P'(DEPTH));

    // R4
    std_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft_mode && !rd_valid) |=> $stable(rd_data));

    // R6
    fwft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft_mode && rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 11
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              fwft_mode
);
    localparam int P = ADDR_W + 1;

    logic [P-1:0]      wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              we;
    logic [DATA_W-1:0] mem_q;

    push_side #(.ADDR_W(ADDR_W)) u_push (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_sync(rgray_s),
        .waddr(waddr), .wgray(wgray), .we(we), .wr_ready(wr_ready)
    );

    ptr_sync #(.W(P), .STAGES(2)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s)
    );

    ptr_sync #(.W(P), .STAGES(2)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s)
    );

    word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    pop_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pop (
        .clk(rd_clk), .rst_n(rd_rst_n), .fwft_mode(fwft_mode), .rd_en(rd_en),
        .wgray_sync(wgray_s), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/tb_xclk_fifo.sv
`timescale 1ns/100ps
module tb_xclk_fifo;
    localparam int DW    = 36;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          wr_en = 0, rd_en = 0, fwft_mode = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_ready, rd_valid;

    int            n_chk = 0, n_fail = 0;
    logic [DW-1:0] q[$];
    int            seq = 0;

    xclk_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .fwft_mode(fwft_mode)
    );

    always #4 wr_clk = ~wr_clk;          // 125 MHz
    always #6.5 rd_clk = ~rd_clk;        // unrelated, edges at x.5 ns

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] next_word();
        seq++;
        return {4'hA, 32'(seq)};
    endfunction

    function automatic bit pick(input int p, input int i);
        if (p == 0) return 1'b1;
        if (p == 1) return ($urandom_range(0, 3) != 0);
        return (i % 7) < 2;
    endfunction

    task automatic do_reset(input bit mode);
        wr_rst_n = 0; rd_rst_n = 0; wr_en = 0; rd_en = 0; fwft_mode = mode;
        q.delete();
        #30;
        chk(wr_ready == 1'b0, "R1 wr_ready in reset", 64'(wr_ready), 0);
        chk(rd_valid == 1'b0, "R1 rd_valid in reset", 64'(rd_valid), 0);
        @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        @(posedge wr_clk); #1;
        chk(wr_ready == 1'b1, "R1 wr_ready after release", 64'(wr_ready), 1);
        chk(rd_valid == 1'b0, "R1 rd_valid after release", 64'(rd_valid), 0);
    endtask

    task automatic feed(input int n, input int pat);
        int acc = 0;
        int i = 0;
        while (acc < n) begin
            bit go;
            @(negedge wr_clk);
            go = pick(pat, i);
            i++;
            if (go) begin
                wr_en = 1; wr_data = next_word();
                if (wr_ready) begin q.push_back(wr_data); acc++; end
            end else wr_en = 0;
        end
        @(negedge wr_clk); wr_en = 0;
    endtask

    task automatic drain(input int n, input int pat);
        int got = 0;
        int i = 0;
        bit pend = 0, ign = 0;
        logic [DW-1:0] exp, hold;
        while (got < n) begin
            bit go;
            @(negedge rd_clk);
            if (!fwft_mode) begin
                if (pend) begin
                    chk(rd_data == exp, "R2 R4 std order", 64'(rd_data), 64'(exp));
                    pend = 0; got++;
                end
                if (ign) begin
                    chk(rd_data == hold, "R4 ignored read", 64'(rd_data), 64'(hold));
                    ign = 0;
                end
                if (got >= n) begin rd_en = 0; break; end
                go = pick(pat, i); i++;
                rd_en = go;
                if (go && rd_valid) begin exp = q.pop_front(); pend = 1; end
                else if (go) begin ign = 1; hold = rd_data; end
            end else begin
                go = pick(pat, i); i++;
                if (rd_valid) begin
                    chk(rd_data == q[0], "R2 R6 fwft order", 64'(rd_data), 64'(q[0]));
                    if (go) begin void'(q.pop_front()); got++; end
                end
                rd_en = go;
            end
        end
        @(negedge rd_clk); rd_en = 0;
    endtask

    task automatic latency_test(input bit mode);
        logic [DW-1:0] w;
        int n = 0;
        do_reset(mode);
        @(negedge wr_clk);
        w = next_word(); wr_en = 1; wr_data = w; q.push_back(w);
        @(posedge wr_clk);
        fork begin #1 wr_en = 0; end join_none
        for (int k = 0; k < 10; k++) begin
            @(posedge rd_clk); n++; #1;
            if (rd_valid) break;
        end
        if (!mode) begin
            chk(n == 2, "R3 std flag latency", 64'(n), 2);
            chk(rd_data == '0, "R4 no load without request", 64'(rd_data), 0);
        end else begin
            chk(n == 3, "R5 fwft flag latency", 64'(n), 3);
            chk(rd_data == w, "R5 fwft word shown", 64'(rd_data), 64'(w));
        end
        drain(1, 0);
    endtask

    task automatic fill_test(input bit mode);
        int cnt;
        int n = 0;
        logic [DW-1:0] exp;
        do_reset(mode);
        feed(1, 0);
        cnt = 1;
        repeat (12) @(negedge wr_clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge wr_clk);
            if (!wr_ready) begin wr_en = 0; break; end
            wr_en = 1; wr_data = next_word(); q.push_back(wr_data); cnt++;
        end
        wr_en = 0;
        chk(cnt == DEPTH + int'(mode), "R9 R7 words accepted", 64'(cnt), 64'(DEPTH + int'(mode)));
        @(negedge wr_clk); wr_en = 1; wr_data = {4'hD, 32'hDEAD};
        @(negedge wr_clk); wr_en = 0;
        chk(wr_ready == 1'b0, "R7 still full", 64'(wr_ready), 0);
        @(negedge rd_clk);
        if (!mode) exp = q.pop_front();
        else begin
            chk(rd_data == q[0], "R6 head shown", 64'(rd_data), 64'(q[0]));
            exp = q.pop_front();
        end
        rd_en = 1;
        @(posedge rd_clk);
        fork begin #1 rd_en = 0; end join_none
        for (int k = 0; k < 10; k++) begin
            @(posedge wr_clk); n++; #1;
            if (wr_ready) break;
        end
        chk(n == 2, "R8 wr_ready latency", 64'(n), 2);
        if (!mode) chk(rd_data == exp, "R4 read data", 64'(rd_data), 64'(exp));
        drain(q.size(), 0);
        repeat (6) @(negedge rd_clk);
        chk(rd_valid == 1'b0, "R7 ignored write not stored", 64'(rd_valid), 0);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            latency_test(bit'(m));
            fill_test(bit'(m));
            for (int p = 0; p < 3; p++) begin
                int pw, pr;
                pw = (p == 0) ? 0 : (p == 1) ? 2 : 1;
                pr = (p == 0) ? 2 : (p == 1) ? 0 : 1;
                do_reset(bit'(m));
                fork
                    feed(60, pw);
                    drain(60, pr);
                join
                repeat (6) @(negedge rd_clk);
                chk(rd_valid == 1'b0, "R2 nothing extra", 64'(rd_valid), 0);
                chk(q.size() == 0, "R2 all words seen", 64'(q.size()), 0);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule